// File: doc/BRIEF.md
# UART Line Status Register Logic

This block builds the line status byte of one UART channel and the two interrupt requests that come from it. It follows the occupancy of the receive buffer or receive FIFO and of the transmit holding register or transmit FIFO. It does this by counting the push, pop, write and load strobes that the datapath already produces. It keeps the parity, framing and break tags of received characters in a form the CPU can read. The serial engines and the FIFO data storage sit outside the block. The receive FIFO storage reports the error tag of its current head character on `rx_head_err`.

The channel runs in one of two modes. With `fifo_mode` low, there is a single receive buffer and a single transmit holding register. A new received character overwrites the one already held. With `fifo_mode` high, both paths are FIFOs of a parameterised depth. Each received character carries its own error tag. That tag appears in the status byte only while its character is at the head of the FIFO. A summary bit reports whether any held character carries an error. Reading the status byte clears the overrun flag and the error flags that are currently shown.

Top module: `uart_lsr_core`

## Requirements
- R1: After reset the status byte reads 0x60. Bit 5 (holding empty) and bit 6 (transmitter empty) are 1, and every other bit is 0.
- R2: Bit 0 (data ready) is 1 while the receive buffer, or the receive FIFO in FIFO mode, holds at least one character. A pop when nothing is held is ignored.
- R3: Bit 1 (overrun) sets on a push into a full receive path and stays set until the status byte is read. In non-FIFO mode the held character is replaced. In FIFO mode the pushed character is dropped. A push in the same cycle as a pop is not an overrun.
- R4: Bits 2, 3 and 4 show parity, framing and break. Their error-tag encoding is {break, framing, parity} on bits [2:0].
  - In non-FIFO mode these bits take the tag of each loaded character, so a clean character clears break.
  - In FIFO mode they take the tag of the head character. A character pushed into an empty FIFO shows its tag one cycle after the push. After a pop the next head's tag shows two cycles after the pop.
  - In both modes, a status read clears these bits unless a new head is loaded in the same cycle.
- R5: Bit 7 is 1 in FIFO mode while any held character has a nonzero error tag. It is 0 in non-FIFO mode.
- R6: In non-FIFO mode, bit 5 clears in the cycle after a holding-register write. It sets in the cycle after a load into the shift register. A write and a load in the same cycle leave it clear.
- R7: In FIFO mode, bit 5 is 1 exactly while the transmit FIFO is empty. A write when the FIFO is full and no load occurs is dropped.
- R8: Bit 6 is 1 only when bit 5 is 1 and `tx_shift_busy` is low.
- R9: A read at address 5 returns the status byte on `rd_data`. Any other address returns 0. Writes have no effect. A cycle with both `rd_en` and `wr_en` high does not clear anything.
- R10: `irq_rls` is high when `rls_ie` is high and any of bits 1 to 4 is set. `irq_thre` is high when `thre_ie` is high and bit 5 is set.
- R11: A change of `fifo_mode` empties both paths and clears overrun, the error flags and bit 7. The status byte returns to 0x60 if `tx_shift_busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fifo_mode | input | 1 | 1 selects FIFO mode, 0 selects single-register mode |
| rx_push | input | 1 | A received character is stored |
| rx_push_err | input | 3 | Error tag of the stored character, {break, framing, parity} |
| rx_pop | input | 1 | CPU takes the head received character |
| rx_head_err | input | 3 | Error tag of the character now at the receive FIFO head |
| tx_wr | input | 1 | CPU writes a character for transmission |
| tx_load | input | 1 | Shift engine takes the next character to send |
| tx_shift_busy | input | 1 | Transmit shift register holds a character |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register offset |
| rls_ie | input | 1 | Receiver line status interrupt enable |
| thre_ie | input | 1 | Holding empty interrupt enable |
| rd_data | output | 8 | Read data |
| lsr_o | output | 8 | Current status byte |
| irq_rls | output | 1 | Receiver line status interrupt request |
| irq_thre | output | 1 | Holding empty interrupt request |

## Verification
The hardest state to reach is a FIFO head change where the next character's error tag must show only after that character reaches the head, while bit 7 still reports errors deeper in the FIFO. The bench fills the FIFO with an error-tagged character, a clean one and a break-tagged one. It reads the status byte once and then pops one character at a time. At each step it checks that the shown flags and the summary bit move apart. A bench-side model of the FIFO tag storage drives `rx_head_err`. Filling either FIFO past its depth by pushes or writes checks the overrun and drop behaviour.

// File: rtl/uart_lsr_pkg.sv
`timescale 1ns/1ps
package uart_lsr_pkg;
  localparam int LSR_DR    = 0;
  localparam int LSR_OE    = 1;
  localparam int LSR_PE    = 2;
  localparam int LSR_FE    = 3;
  localparam int LSR_BI    = 4;
  localparam int LSR_THRE  = 5;
  localparam int LSR_TEMT  = 6;
  localparam int LSR_RXERR = 7;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rx_tag_t;

  function automatic logic tag_any(rx_tag_t t);
    return t.brk | t.frm | t.par;
  endfunction

  function automatic logic [7:0] lsr_pack(logic dr, logic oe, rx_tag_t t,
                                          logic thre, logic temt, logic rxerr);
    return {rxerr, temt, thre, t.brk, t.frm, t.par, oe, dr};
  endfunction
endpackage

// File: rtl/uart_lsr_rx_track.sv
`timescale 1ns/1ps
module uart_lsr_rx_track
  import uart_lsr_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    fifo_mode,
  input  logic    clear,
  input  logic    push,
  input  rx_tag_t push_tag,
  input  logic    pop,
  input  rx_tag_t head_tag,
  input  logic    lsr_rd,
  output logic    data_ready,
  output logic    overrun,
  output rx_tag_t shown_tag,
  output logic    err_held,
  output logic    pop_ok,
  output logic    head_pend
);
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [CW-1:0] step(logic [CW-1:0] v, logic up, logic dn);
    return v + CW'(up) - CW'(dn);
  endfunction

  logic [CW-1:0] cnt_q, cnt_d, err_q, err_d;
  logic          oe_q, oe_d, pend_q, pend_d;
  rx_tag_t       tag_q, tag_d;
  logic          has, full, accept, ovr_evt, head_new, err_dn;

  assign has      = (cnt_q != '0);
  assign full     = fifo_mode ? (cnt_q == CW'(DEPTH)) : has;
  assign pop_ok   = pop && has;
  assign accept   = push && (!fifo_mode || !full || pop_ok);
  assign ovr_evt  = push && full && !pop_ok;
  assign head_new = accept && ((cnt_q == '0) || (pop_ok && cnt_q == CW'(1)));
  assign err_dn   = pop_ok && tag_any(head_tag) && (err_q != '0);

  always_comb begin
    cnt_d  = fifo_mode ? step(cnt_q, accept, pop_ok)
                       : (push ? CW'(1) : (pop_ok ? '0 : cnt_q));
    err_d  = fifo_mode ? step(err_q, accept && tag_any(push_tag), err_dn) : '0;
    oe_d   = ovr_evt ? 1'b1 : (lsr_rd ? 1'b0 : oe_q);
    tag_d  = tag_q;
    pend_d = 1'b0;
    if (!fifo_mode) begin
      if (push)        tag_d = push_tag;
      else if (lsr_rd) tag_d = '0;
    end else if (head_new) begin
      tag_d = push_tag;
    end else if (pop_ok) begin
      tag_d  = '0;
      pend_d = (cnt_q > CW'(1));
    end else if (pend_q) begin
      tag_d = head_tag;
    end else if (lsr_rd) begin
      tag_d = '0;
    end
    if (clear) begin
      cnt_d  = '0;
      err_d  = '0;
      oe_d   = 1'b0;
      tag_d  = '0;
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      err_q  <= '0;
      oe_q   <= 1'b0;
      tag_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      err_q  <= err_d;
      oe_q   <= oe_d;
      tag_q  <= tag_d;
      pend_q <= pend_d;
    end
  end

  assign data_ready = has;
  assign overrun    = oe_q;
  assign shown_tag  = tag_q;
  assign err_held   = fifo_mode && (err_q != '0);
  assign head_pend  = pend_q;
endmodule

// File: rtl/uart_lsr_tx_track.sv
`timescale 1ns/1ps
module uart_lsr_tx_track #(
  parameter int DEPTH = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fifo_mode,
  input  logic clear,
  input  logic wr,
  input  logic ld,
  output logic hold_empty
);
  localparam int CW = $clog2(DEPTH + 1);

  function automatic logic [CW-1:0] step(logic [CW-1:0] v, logic up, logic dn);
    return v + CW'(up) - CW'(dn);
  endfunction

  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, ld_ok, wr_ok;

  assign full  = fifo_mode ? (cnt_q == CW'(DEPTH)) : (cnt_q != '0);
  assign ld_ok = ld && (cnt_q != '0);
  assign wr_ok = wr && (!fifo_mode || !full || ld_ok);

  always_comb begin
    if (clear)          cnt_d = '0;
    else if (fifo_mode) cnt_d = step(cnt_q, wr_ok, ld_ok);
    else if (wr)        cnt_d = CW'(1);
    else if (ld_ok)     cnt_d = '0;
    else                cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign hold_empty = (cnt_q == '0);
endmodule

// File: rtl/uart_lsr_core.sv
`timescale 1ns/1ps
module uart_lsr_core
  import uart_lsr_pkg::*;
#(
  parameter int                RX_DEPTH = 16,
  parameter int                TX_DEPTH = 16,
  parameter int                ADDR_W   = 3,
  parameter logic [ADDR_W-1:0] LSR_ADDR = ADDR_W'(5)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fifo_mode,
  input  logic              rx_push,
  input  logic [2:0]        rx_push_err,
  input  logic              rx_pop,
  input  logic [2:0]        rx_head_err,
  input  logic              tx_wr,
  input  logic              tx_load,
  input  logic              tx_shift_busy,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rls_ie,
  input  logic              thre_ie,
  output logic [7:0]        rd_data,
  output logic [7:0]        lsr_o,
  output logic              irq_rls,
  output logic              irq_thre
);
  logic    mode_q, mode_chg, lsr_hit, lsr_rd_evt;
  logic    dr, oe, err_held, rx_pop_ok, head_pend, thre, temt;
  rx_tag_t shown_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= 1'b0;
    else        mode_q <= fifo_mode;
  end

  assign mode_chg   = (fifo_mode != mode_q);
  assign lsr_hit    = (addr == LSR_ADDR);
  assign lsr_rd_evt = rd_en && !wr_en && lsr_hit;

  uart_lsr_rx_track #(.DEPTH(RX_DEPTH)) u_rx (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .clear(mode_chg),
    .push(rx_push), .push_tag(rx_tag_t'(rx_push_err)), .pop(rx_pop),
    .head_tag(rx_tag_t'(rx_head_err)), .lsr_rd(lsr_rd_evt),
    .data_ready(dr), .overrun(oe), .shown_tag(shown_tag), .err_held(err_held),
    .pop_ok(rx_pop_ok), .head_pend(head_pend)
  );

  uart_lsr_tx_track #(.DEPTH(TX_DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .clear(mode_chg),
    .wr(tx_wr), .ld(tx_load), .hold_empty(thre)
  );

  assign temt     = thre && !tx_shift_busy;
  assign lsr_o    = lsr_pack(dr, oe, shown_tag, thre, temt, err_held);
  assign rd_data  = (rd_en && lsr_hit) ? lsr_o : 8'h00;
  assign irq_rls  = rls_ie && (oe || tag_any(shown_tag));
  assign irq_thre = thre_ie && thre;
endmodule

// File: rtl/uart_lsr_checker.sv
`timescale 1ns/1ps
module uart_lsr_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       mode_chg,
  input logic [7:0] lsr,
  input logic       lsr_rd_evt,
  input logic       rx_push,
  input logic       rx_pop_ok,
  input logic       head_pend,
  input logic       tx_wr,
  input logic       rls_ie,
  input logic       irq_rls,
  input logic       thre_ie,
  input logic       irq_thre
);
  assert_dr_after_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && !mode_chg |=> lsr[0]);

  assert_oe_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[1] && !lsr_rd_evt && !mode_chg |=> lsr[1]);

  assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_rd_evt && !rx_push && !rx_pop_ok && !head_pend && !mode_chg
    |=> (lsr[4:1] == 4'b0000));

  assert_rxerr_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[7] |-> lsr[0]);

  assert_thre_falls_on_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr && !mode_chg |=> !lsr[5]);

  assert_temt_needs_thre_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lsr[6] |-> lsr[5]);

  assert_rls_irq_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_rls |-> rls_ie && (lsr[4:1] != 4'b0000));

  assert_thre_irq_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_thre |-> thre_ie && lsr[5]);

  assert_mode_change_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> lsr[5] && (lsr[4:0] == 5'b00000) && !lsr[7]);
endmodule

bind uart_lsr_core uart_lsr_checker u_lsr_chk (
  .clk(clk), .rst_n(rst_n), .mode_chg(mode_chg), .lsr(lsr_o),
  .lsr_rd_evt(lsr_rd_evt), .rx_push(rx_push), .rx_pop_ok(rx_pop_ok),
  .head_pend(head_pend), .tx_wr(tx_wr), .rls_ie(rls_ie), .irq_rls(irq_rls),
  .thre_ie(thre_ie), .irq_thre(irq_thre)
);

// File: tb/test_uart_lsr_core.sv
`timescale 1ns/1ps
module test_uart_lsr_core;
  localparam int FDEPTH = 16;
  localparam int NVEC   = 30;
  // op codes: 1 push, 2 pop, 3 status read, 4 tx write, 5 tx load,
  // 6 set busy, 7 register write, 8 set mode, 9 push and pop together
  localparam logic [19:0] VEC [NVEC] = '{
    {4'd1, 8'h00, 8'h61}, {4'd1, 8'h01, 8'h67}, {4'd7, 8'h00, 8'h67},
    {4'd3, 8'h00, 8'h61}, {4'd2, 8'h00, 8'h60}, {4'd1, 8'h04, 8'h71},
    {4'd1, 8'h00, 8'h63}, {4'd3, 8'h00, 8'h61}, {4'd2, 8'h00, 8'h60},
    {4'd4, 8'h00, 8'h00}, {4'd6, 8'h01, 8'h00}, {4'd5, 8'h00, 8'h20},
    {4'd6, 8'h00, 8'h60}, {4'd8, 8'h01, 8'h60}, {4'd1, 8'h02, 8'hE9},
    {4'd1, 8'h00, 8'hE9}, {4'd1, 8'h04, 8'hE9}, {4'd3, 8'h00, 8'hE1},
    {4'd2, 8'h00, 8'hE1}, {4'd2, 8'h00, 8'hF1}, {4'd2, 8'h00, 8'h60},
    {4'd4, 8'h00, 8'h00}, {4'd4, 8'h00, 8'h00}, {4'd5, 8'h00, 8'h00},
    {4'd5, 8'h00, 8'h60}, {4'd9, 8'h01, 8'hE5}, {4'd9, 8'h00, 8'h61},
    {4'd3, 8'h00, 8'h61}, {4'd2, 8'h00, 8'h60}, {4'd8, 8'h00, 8'h60}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fifo_mode = 1'b0;
  logic       rx_push = 1'b0, rx_pop = 1'b0, tx_wr = 1'b0, tx_load = 1'b0;
  logic       tx_shift_busy = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic       rls_ie = 1'b0, thre_ie = 1'b0;
  logic [2:0] rx_push_err = 3'b000, rx_head_err = 3'b000;
  logic [2:0] addr = 3'd0;
  logic [7:0] rd_data, lsr_o;
  logic       irq_rls, irq_thre;

  int         n_vec = 0, n_bad = 0;
  bit         done = 1'b0;
  logic [2:0] q_tag [FDEPTH];
  int         q_n = 0;

  always #5 clk = ~clk;

  uart_lsr_core i_uart_lsr_core (
    .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .rx_push(rx_push),
    .rx_push_err(rx_push_err), .rx_pop(rx_pop), .rx_head_err(rx_head_err),
    .tx_wr(tx_wr), .tx_load(tx_load), .tx_shift_busy(tx_shift_busy),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .rls_ie(rls_ie),
    .thre_ie(thre_ie), .rd_data(rd_data), .lsr_o(lsr_o),
    .irq_rls(irq_rls), .irq_thre(irq_thre)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic string tags_of(int op);
    case (op)
      1, 9:    return "R2 R3 R4 R5";
      2:       return "R2 R4 R5";
      3:       return "R3 R4";
      4, 5:    return "R6 R7 R8";
      6:       return "R8";
      7:       return "R9";
      default: return "R11";
    endcase
  endfunction

  // Bench-side model of the receive FIFO tag storage (FIFO mode only)
  task automatic model_rx(bit do_push, bit do_pop, logic [2:0] tag);
    bit popped = 1'b0;
    bit room   = (q_n < FDEPTH);
    if (do_pop && q_n > 0) begin
      for (int i = 0; i < FDEPTH - 1; i++) q_tag[i] = q_tag[i+1];
      q_n--;
      popped = 1'b1;
    end
    if (do_push && (room || popped)) begin
      q_tag[q_n] = tag;
      q_n++;
    end
  endtask

  task automatic do_op(int op, logic [7:0] arg);
    @(negedge clk);
    case (op)
      1: begin rx_push = 1'b1; rx_push_err = arg[2:0]; end
      2: rx_pop = 1'b1;
      3: begin rd_en = 1'b1; addr = 3'd5; end
      4: tx_wr = 1'b1;
      5: tx_load = 1'b1;
      6: tx_shift_busy = arg[0];
      7: begin wr_en = 1'b1; addr = 3'd5; end
      8: fifo_mode = arg[0];
      9: begin rx_push = 1'b1; rx_pop = 1'b1; rx_push_err = arg[2:0]; end
      default: ;
    endcase
    @(posedge clk);
    @(negedge clk);
    rx_push = 1'b0; rx_pop = 1'b0; tx_wr = 1'b0; tx_load = 1'b0;
    rd_en = 1'b0; wr_en = 1'b0; addr = 3'd0;
    if (op == 8) q_n = 0;
    else if (fifo_mode) model_rx(op == 1 || op == 9, op == 2 || op == 9, arg[2:0]);
    rx_head_err = (q_n > 0) ? q_tag[0] : 3'b000;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 / R9: reset value, address decode
    check("R1 reset status", lsr_o, 8'h60);
    rd_en = 1'b1; addr = 3'd5; #1;
    check("R9 read at offset 5", rd_data, 8'h60);
    addr = 3'd4; #1;
    check("R9 other offset reads zero", rd_data, 8'h00);
    rd_en = 1'b0; addr = 3'd0;

    for (int v = 0; v < NVEC; v++) begin
      do_op(int'(VEC[v][19:16]), VEC[v][15:8]);
      check($sformatf("vector %0d (%s)", v, tags_of(int'(VEC[v][19:16]))),
            lsr_o, VEC[v][7:0]);
    end

    // R3: FIFO overrun drops the extra character
    do_op(8, 8'h01);
    for (int i = 0; i < FDEPTH + 1; i++) do_op(1, 8'h00);
    check("R3 fifo overrun sets bit 1", lsr_o, 8'h63);
    for (int i = 0; i < FDEPTH; i++) do_op(2, 8'h00);
    check("R2 R3 empty after depth pops, overrun sticky", lsr_o, 8'h62);
    do_op(3, 8'h00);
    check("R3 read clears overrun", lsr_o, 8'h60);

    // R7: transmit FIFO drops a write when full
    for (int i = 0; i < FDEPTH + 1; i++) do_op(4, 8'h00);
    for (int i = 0; i < FDEPTH - 1; i++) do_op(5, 8'h00);
    check("R7 one entry left", lsr_o, 8'h00);
    do_op(5, 8'h00);
    check("R7 empty after depth loads", lsr_o, 8'h60);

    // R10: interrupt requests
    rls_ie = 1'b1; thre_ie = 1'b1;
    @(negedge clk);
    check("R10 thre irq when empty", {7'd0, irq_thre}, 8'h01);
    check("R10 no rls irq when clean", {7'd0, irq_rls}, 8'h00);
    do_op(1, 8'h01);
    check("R4 R5 parity at head", lsr_o, 8'hE5);
    check("R10 rls irq on parity", {7'd0, irq_rls}, 8'h01);

    // R9: combined read and write strobe clears nothing
    @(negedge clk);
    rd_en = 1'b1; wr_en = 1'b1; addr = 3'd5;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0; addr = 3'd0;
    @(negedge clk);
    check("R9 read with write strobe ignored", lsr_o, 8'hE5);

    do_op(3, 8'h00);
    check("R10 rls irq drops after read", {7'd0, irq_rls}, 8'h00);
    do_op(4, 8'h00);
    check("R10 thre irq drops after write", {7'd0, irq_thre}, 8'h00);

    // R11: mode change empties both paths
    do_op(1, 8'h02);
    do_op(8, 8'h00);
    check("R11 mode change clears status", lsr_o, 8'h60);
    check("R11 R10 thre irq back", {7'd0, irq_thre}, 8'h01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule